// File: doc/BRIEF.md
# Tiny Load/Store CPU

This block is a small multi-cycle processor core with an 8-bit datapath and a 10-bit byte address space. Its programmer-visible state is two 8-bit working registers A and B, one carry flag and a 10-bit program counter. It drives a single synchronous byte memory through an address, a write-data byte, a write enable and a read-data byte. Read data is expected one clock after the address is presented.

Instructions are one or two bytes long. The upper nibble of the first byte selects the operation. Four single-byte ALU operations work on A, B and carry. The two-byte instructions take a 10-bit operand n: its bits 9:8 are the two low bits of the first byte and its bits 7:0 are the second byte. Loads go into B, and stores always write A. Both can be immediate, direct, or indirect through a page-zero pointer held in memory.

Control flow has three forms. A carry-conditional jump. A swap of the PC with the {B,A} pair, which serves as call, return and computed jump. A halt byte that freezes the core for simulation. Each instruction runs through a small state machine: first fetch, optional second fetch, optional pointer read, then the data access or the update step.

Top module: `tiny_ls_cpu`

## Requirements
- R1: While reset is asserted, and after it is released, the first fetch address is 0x100 and no write is issued. A, B and carry start at zero.
- R2: Opcode nibble 0000 (one byte) computes a+b+c and writes the low 8 bits to A and the carry-out to carry.
- R3: Opcode nibble 0001 (one byte) replaces A with its bitwise inverse.
- R4: Opcode nibble 0010 (one byte) sets A to A AND B and clears carry.
- R5: Opcode nibble 0011 (one byte) exchanges A and B.
- R6: Opcode nibble 1000 loads the second byte into B. The low nibble of the first byte has no effect.
- R7: Opcode nibble 1001 loads B from address n, and opcode nibble 0110 writes A to address n. Here n is {first byte bits 1:0, second byte}, and first byte bits 3:2 are ignored.
- R8: Opcode nibbles 1100 (load B) and 1010 (store A) read a pointer byte p at address n and then access address {2'b00, p}, which is always in page zero.
- R9: Opcode nibble 0100 sets the PC to n when carry is 1. Otherwise execution continues at the byte after the instruction.
- R10: Opcode nibble 0111 is two bytes, and its second byte is ignored. It sets the PC to {B[1:0], A}. A then receives bits 7:0 of the address after the instruction, and B receives that address's bits 9:8, zero-extended.
- R11: The byte 0xFF halts the core. The halt output stays high, and no further write or state change occurs until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | 10 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data (always A) |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 8 | Memory read data, valid one cycle after address |
| halted_o | output | 1 | High once a halt byte has executed |

## Verification
Directed programs cover several cases. They chain ALU operations whose results depend on a carry from an earlier add. They check that an AND between two adds clears carry. They check a store placed after a halt. Each directed run reads the results from memory at the expected addresses. Pointer programs preload a page-zero target and a same-offset address in a higher page, so a pointer that keeps upper address bits writes to the wrong place. Jump programs place marker stores on both the taken and the not-taken path. The swap program checks the exact return address left in A and B. Random programs mix every instruction kind, including conditional jumps over an immediate load, and put random values in the ignored opcode bits. Each run ends by dumping A, B and carry to memory. The whole memory image is then compared against an instruction-level model in the bench.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  localparam logic [3:0] OPC_ADC  = 4'h0;
  localparam logic [3:0] OPC_NOT  = 4'h1;
  localparam logic [3:0] OPC_AND  = 4'h2;
  localparam logic [3:0] OPC_AXB  = 4'h3;
  localparam logic [3:0] OPC_JPC  = 4'h4;
  localparam logic [3:0] OPC_STA  = 4'h6;
  localparam logic [3:0] OPC_JAL  = 4'h7;
  localparam logic [3:0] OPC_LDBI = 4'h8;
  localparam logic [3:0] OPC_LDB  = 4'h9;
  localparam logic [3:0] OPC_STAP = 4'hA;
  localparam logic [3:0] OPC_LDBP = 4'hC;
  localparam logic [7:0] HALT_BYTE = 8'hFF;

  typedef enum logic [2:0] {
    ST_FETCH = 3'd0,
    ST_DEC1  = 3'd1,
    ST_DEC2  = 3'd2,
    ST_PTR   = 3'd3,
    ST_LOAD  = 3'd4,
    ST_HALT  = 3'd5
  } state_e;

  typedef struct packed {
    logic [1:0] alu_fn;
    logic       short_op;
    logic       is_halt;
    logic       ld_imm;
    logic       ld_dir;
    logic       st_dir;
    logic       ld_ptr;
    logic       st_ptr;
    logic       jpc;
    logic       jal;
  } dec_t;
endpackage

// File: rtl/tlc_decode.sv
module tlc_decode
  import tlc_pkg::*;
(
  input  logic [7:0] byte_i,
  output dec_t       dec_o
);
  always_comb begin
    dec_o          = '0;
    dec_o.alu_fn   = byte_i[5:4];
    dec_o.is_halt  = (byte_i == HALT_BYTE);
    dec_o.short_op = (byte_i[7:6] == 2'b00);
    unique case (byte_i[7:4])
      OPC_LDBI: dec_o.ld_imm = 1'b1;
      OPC_LDB:  dec_o.ld_dir = 1'b1;
      OPC_STA:  dec_o.st_dir = 1'b1;
      OPC_LDBP: dec_o.ld_ptr = 1'b1;
      OPC_STAP: dec_o.st_ptr = 1'b1;
      OPC_JPC:  dec_o.jpc    = 1'b1;
      OPC_JAL:  dec_o.jal    = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/tlc_alu.sv
module tlc_alu #(
  parameter int DATA_W = 8
) (
  input  logic [1:0]        fn_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o,
  output logic              c_o
);
  logic [DATA_W:0] sum;

  assign sum = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, c_i};

  always_comb begin
    a_o = a_i;
    b_o = b_i;
    c_o = c_i;
    unique case (fn_i)
      2'd0: begin a_o = sum[DATA_W-1:0]; c_o = sum[DATA_W]; end
      2'd1: a_o = ~a_i;
      2'd2: begin a_o = a_i & b_i; c_o = 1'b0; end
      default: begin a_o = b_i; b_o = a_i; end
    endcase
  end
endmodule

// File: rtl/tiny_ls_cpu.sv
module tiny_ls_cpu
  import tlc_pkg::*;
#(
  parameter int                    ADDR_W   = 10,
  parameter int                    DATA_W   = 8,
  parameter logic [ADDR_W-1:0]     RESET_PC = 'h100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              halted_o
);
  localparam int HI_W = ADDR_W - DATA_W;
  localparam logic [ADDR_W-1:0] PC_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  state_e            state_q, state_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [DATA_W-1:0] a_q, a_d, b_q, b_d;
  logic              c_q, c_d;
  logic [7:0]        ir_q, ir_d;

  logic [7:0]        dec_byte;
  dec_t              dec;
  logic [DATA_W-1:0] alu_a, alu_b;
  logic              alu_c;
  logic [ADDR_W-1:0] opnd;
  logic [ADDR_W-1:0] ptr_addr;

  // decode the live byte in DEC1, the latched one afterwards
  assign dec_byte = (state_q == ST_DEC1) ? mem_rdata_i[7:0] : ir_q;
  assign opnd     = {ir_q[HI_W-1:0], mem_rdata_i};
  assign ptr_addr = {{HI_W{1'b0}}, mem_rdata_i};
  assign halted_o = (state_q == ST_HALT);

  tlc_decode u_dec (
    .byte_i (dec_byte),
    .dec_o  (dec)
  );

  tlc_alu #(.DATA_W(DATA_W)) u_alu (
    .fn_i (dec.alu_fn),
    .a_i  (a_q),
    .b_i  (b_q),
    .c_i  (c_q),
    .a_o  (alu_a),
    .b_o  (alu_b),
    .c_o  (alu_c)
  );

  always_comb begin
    state_d     = state_q;
    pc_d        = pc_q;
    a_d         = a_q;
    b_d         = b_q;
    c_d         = c_q;
    ir_d        = ir_q;
    mem_addr_o  = pc_q;
    mem_wdata_o = a_q;
    mem_we_o    = 1'b0;
    unique case (state_q)
      ST_FETCH: begin
        pc_d    = pc_q + PC_ONE;
        state_d = ST_DEC1;
      end
      ST_DEC1: begin
        ir_d = mem_rdata_i[7:0];
        if (dec.is_halt) begin
          state_d = ST_HALT;
        end else if (dec.short_op) begin
          a_d     = alu_a;
          b_d     = alu_b;
          c_d     = alu_c;
          state_d = ST_FETCH;
        end else begin
          // second byte fetched at pc_q
          pc_d    = pc_q + PC_ONE;
          state_d = ST_DEC2;
        end
      end
      ST_DEC2: begin
        state_d = ST_FETCH;
        if (dec.ld_imm) begin
          b_d = mem_rdata_i;
        end else if (dec.ld_dir) begin
          mem_addr_o = opnd;
          state_d    = ST_LOAD;
        end else if (dec.st_dir) begin
          mem_addr_o = opnd;
          mem_we_o   = 1'b1;
        end else if (dec.ld_ptr || dec.st_ptr) begin
          mem_addr_o = opnd;
          state_d    = ST_PTR;
        end else if (dec.jpc) begin
          if (c_q) pc_d = opnd;
        end else if (dec.jal) begin
          pc_d = {b_q[HI_W-1:0], a_q};
          a_d  = pc_q[DATA_W-1:0];
          b_d  = {{(DATA_W-HI_W){1'b0}}, pc_q[ADDR_W-1:DATA_W]};
        end
      end
      ST_PTR: begin
        mem_addr_o = ptr_addr;
        if (dec.st_ptr) begin
          mem_we_o = 1'b1;
          state_d  = ST_FETCH;
        end else begin
          state_d  = ST_LOAD;
        end
      end
      ST_LOAD: begin
        b_d     = mem_rdata_i;
        state_d = ST_FETCH;
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      pc_q    <= RESET_PC;
      a_q     <= '0;
      b_q     <= '0;
      c_q     <= 1'b0;
      ir_q    <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      a_q     <= a_d;
      b_q     <= b_d;
      c_q     <= c_d;
      ir_q    <= ir_d;
    end
  end

  a_r1_fetch_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH) |-> (mem_addr_o == pc_q && !mem_we_o));

  a_r4_and_clears_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEC1 && dec.short_op && dec.alu_fn == 2'd2) |=> !c_q);

  a_r7_write_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_wdata_o == a_q && (state_q == ST_DEC2 || state_q == ST_PTR)));

  a_r8_ptr_page0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PTR) |-> (mem_addr_o[ADDR_W-1:DATA_W] == '0));

  a_r9_jpc_fallthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEC2 && dec.jpc && !c_q) |=> (pc_q == $past(pc_q)));

  a_r10_jal_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEC2 && dec.jal) |=>
      (pc_q == {$past(b_q[HI_W-1:0]), $past(a_q)} && a_q == $past(pc_q[DATA_W-1:0])));

  a_r11_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && !mem_we_o && $stable(a_q) && $stable(b_q) && $stable(pc_q)));
endmodule

// File: tb/tiny_ls_cpu_tb_top.sv
module tiny_ls_cpu_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] mem_addr_o;
  logic [7:0] mem_wdata_o;
  logic       mem_we_o;
  logic [7:0] mem_rdata_i;
  logic       halted_o;

  logic [7:0] mem [0:1023];
  logic [7:0] rm  [0:1023];
  logic [7:0] img [0:1023];
  logic [9:0] wp;
  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk_i = ~clk_i;

  tiny_ls_cpu dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .mem_rdata_i (mem_rdata_i),
    .halted_o    (halted_o)
  );

  always @(posedge clk_i) begin
    mem_rdata_i <= mem[mem_addr_o];
    if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < 1024; i++) img[i] = 8'h00;
    wp = 10'h100;
  endtask

  task automatic e1(input logic [3:0] op);
    img[wp] = {op, 4'($urandom_range(0, 15))};
    wp = wp + 10'd1;
  endtask

  task automatic e2(input logic [3:0] op, input logic [9:0] n);
    img[wp] = {op, 2'($urandom_range(0, 3)), n[9:8]};
    img[wp + 10'd1] = n[7:0];
    wp = wp + 10'd2;
  endtask

  task automatic ehalt();
    img[wp] = 8'hFF;
    img[wp + 10'd1] = 8'($urandom_range(0, 255));
    wp = wp + 10'd2;
  endtask

  // instruction-level model
  task automatic ref_run();
    logic [9:0] pc, n, npc;
    logic [7:0] a, b, op, o2, t;
    logic [8:0] s;
    logic       c;
    pc = 10'h100; a = 0; b = 0; c = 0;
    for (int k = 0; k < 5000; k++) begin
      op = rm[pc]; pc = pc + 10'd1;
      if (op == 8'hFF) break;
      if (op[7:6] == 2'b00) begin
        case (op[5:4])
          2'd0: begin s = {1'b0, a} + {1'b0, b} + {8'd0, c}; a = s[7:0]; c = s[8]; end
          2'd1: a = ~a;
          2'd2: begin a = a & b; c = 1'b0; end
          default: begin t = a; a = b; b = t; end
        endcase
      end else begin
        o2 = rm[pc]; pc = pc + 10'd1; n = {op[1:0], o2};
        case (op[7:4])
          4'h8: b = o2;
          4'h9: b = rm[n];
          4'h6: rm[n] = a;
          4'hC: b = rm[{2'b00, rm[n]}];
          4'hA: rm[{2'b00, rm[n]}] = a;
          4'h4: if (c) pc = n;
          4'h7: begin npc = {b[1:0], a}; a = pc[7:0]; b = {6'd0, pc[9:8]}; pc = npc; end
          default: ;
        endcase
      end
    end
  endtask

  // dumps A to 3F0, B to 3F1, carry to 3F2, then halts
  task automatic dump_and_halt();
    e2(4'h6, 10'h3F0);
    e1(4'h3);
    e2(4'h6, 10'h3F1);
    e2(4'h8, 10'h000);
    e1(4'h3);
    e2(4'h8, 10'h000);
    e1(4'h0);
    e2(4'h6, 10'h3F2);
    ehalt();
  endtask

  task automatic run_prog(input string name);
    int cyc;
    int mism;
    int first;
    rst_ni = 1'b0;
    for (int i = 0; i < 1024; i++) begin mem[i] = img[i]; rm[i] = img[i]; end
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check({"R1 reset fetch addr ", name}, {22'd0, mem_addr_o}, 32'h100);
    check({"R1 no write in reset ", name}, {31'd0, mem_we_o}, 32'd0);
    rst_ni = 1'b1;
    cyc = 0;
    while (!halted_o && cyc < 20000) begin
      @(negedge clk_i);
      if (mem_we_o && halted_o) check("R11 write while halted", 1, 0);
      cyc++;
    end
    check({"R11 halt reached ", name}, {31'd0, halted_o}, 32'd1);
    ref_run();
    mism = 0; first = -1;
    for (int i = 0; i < 1024; i++)
      if (mem[i] !== rm[i]) begin mism++; if (first < 0) first = i; end
    if (first >= 0)
      $display("  %s first mismatch at %0h: dut=%0h model=%0h", name, first, mem[first], rm[first]);
    check({"R2 R3 R4 R5 R6 R7 R8 R9 R10 model match ", name}, mism, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R11 watchdog act=running exp=halted");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));

    // ALU chain: R2 R3 R4 R5
    clear_img();
    e2(4'h8, 10'h0C8); e1(4'h3); e2(4'h8, 10'h050);
    e1(4'h0); e2(4'h6, 10'h300);
    e1(4'h0); e2(4'h6, 10'h301);
    e2(4'h8, 10'h00F); e1(4'h2); e2(4'h6, 10'h302);
    e1(4'h1); e2(4'h6, 10'h303);
    e1(4'h3); e2(4'h6, 10'h304);
    ehalt();
    run_prog("alu");
    check("R2 adc with carry out", mem[10'h300], 8'h18);
    check("R2 adc consumes carry", mem[10'h301], 8'h69);
    check("R4 and result", mem[10'h302], 8'h09);
    check("R3 not result", mem[10'h303], 8'hF6);
    check("R5 swap result", mem[10'h304], 8'h0F);

    // R4 and clears carry
    clear_img();
    e2(4'h8, 10'h0FF); e1(4'h3); e2(4'h8, 10'h001); e1(4'h0);
    e2(4'h8, 10'h0FF); e1(4'h2); e2(4'h8, 10'h000); e1(4'h0);
    e2(4'h6, 10'h305);
    ehalt();
    run_prog("and_carry");
    check("R4 carry cleared by and", mem[10'h305], 8'h00);

    // R6 R7 direct with 10-bit address
    clear_img();
    img[10'h2E1] = 8'h77;
    e2(4'h8, 10'h35A); e1(4'h3); e2(4'h6, 10'h3C7);
    e2(4'h9, 10'h2E1); e1(4'h3); e2(4'h6, 10'h0E0);
    ehalt();
    run_prog("direct");
    check("R6 R7 store of immediate", mem[10'h3C7], 8'h5A);
    check("R7 load from high address", mem[10'h0E0], 8'h77);

    // R8 pointer modes
    clear_img();
    img[10'h230] = 8'h40; img[10'h040] = 8'hA5;
    img[10'h231] = 8'h55; img[10'h355] = 8'h11; img[10'h155] = 8'h22;
    e2(4'hC, 10'h230); e1(4'h3); e2(4'hA, 10'h231);
    ehalt();
    run_prog("pointer");
    check("R8 pointer store page zero", mem[10'h055], 8'hA5);
    check("R8 high page untouched", mem[10'h355], 8'h11);
    check("R8 pointer cell untouched", mem[10'h231], 8'h55);

    // R9 conditional jump
    clear_img();
    e2(4'h8, 10'h011); e1(4'h3); e2(4'h4, 10'h180);
    e2(4'h6, 10'h310); e2(4'h8, 10'h0F0); e1(4'h0);
    e2(4'h4, 10'h1C0); e2(4'h8, 10'h099); e1(4'h3); e2(4'h6, 10'h311); ehalt();
    wp = 10'h180; e2(4'h6, 10'h313); ehalt();
    wp = 10'h1C0; e2(4'h8, 10'h022); e1(4'h3); e2(4'h6, 10'h312); ehalt();
    run_prog("jpc");
    check("R9 not taken falls through", mem[10'h310], 8'h11);
    check("R9 not taken skips target", mem[10'h313], 8'h00);
    check("R9 taken skips fallthrough", mem[10'h311], 8'h00);
    check("R9 taken reaches target", mem[10'h312], 8'h22);

    // R10 swap jump
    clear_img();
    e2(4'h8, 10'h040); e1(4'h3); e2(4'h8, 10'h001); e2(4'h7, 10'h3FF);
    ehalt();
    wp = 10'h140; e2(4'h6, 10'h320); e1(4'h3); e2(4'h6, 10'h321); ehalt();
    run_prog("jal");
    check("R10 return low byte in A", mem[10'h320], 8'h07);
    check("R10 return high bits in B", mem[10'h321], 8'h01);

    // R11 halt
    clear_img();
    e2(4'h8, 10'h066); e1(4'h3); ehalt(); e2(4'h6, 10'h330);
    run_prog("halt");
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk_i);
        if (!halted_o || mem_we_o) bad++;
      end
      check("R11 stays halted without writes", bad, 0);
    end
    check("R11 store after halt not done", mem[10'h330], 8'h00);

    // random programs against the model
    for (int t = 0; t < 8; t++) begin
      clear_img();
      for (int i = 10'h200; i < 10'h3F0; i++) img[i] = 8'($urandom_range(0, 255));
      for (int i = 0; i < 16; i++) img[i] = 8'($urandom_range(16, 255));
      e2(4'h8, 10'($urandom_range(0, 1023)));
      e1(4'h3);
      for (int i = 0; i < 40; i++) begin
        case ($urandom_range(0, 9))
          0, 1, 2, 3: e1(4'($urandom_range(0, 3)));
          4: e2(4'h8, 10'($urandom_range(0, 1023)));
          5: e2(4'h9, 10'($urandom_range(10'h200, 10'h3EF)));
          6: e2(4'h6, 10'($urandom_range(10'h200, 10'h3EF)));
          7: e2(4'hC, 10'($urandom_range(0, 15)));
          8: e2(4'hA, 10'($urandom_range(0, 15)));
          default: begin e2(4'h4, wp + 10'd4); e2(4'h8, 10'($urandom_range(0, 1023))); end
        endcase
      end
      dump_and_halt();
      run_prog("random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule